// File: doc/BRIEF.md
# NOR Flash Block Erase Sequencer

This engine erases one block of a parallel NOR flash over a plain word-wide memory bus. The bus has an address, write data, read data and separate write and read strobes, and it carries at most one access per clock. A client pulses `start` with a block address and a flag that says whether the device has a boot region. The engine then runs the whole erase on its own. For each region it clears the device status, issues the two-step erase command and polls the status word until the device reports ready or a poll budget runs out. It then returns the device to read mode, ranks any error flags into one code, and reads the region back word by word to confirm that it is blank.

A normal block is a single region of `BLOCK_WORDS` words. When the device has a boot region and the block lies at the configured boot offset inside its device, the block is split into sub-sectors. Their lengths come from a small parameter table and they are erased one after another at consecutive addresses. A zero entry ends the list. The final three-bit code is held on `err_code` from the single-cycle `done` pulse until the next accepted start.

Top module: `nor_erase_seq`

## Requirements
- R1: After reset, `busy`, `done`, `flash_we`, `bus_wr` and `bus_rd` are all low.
- R2: Each region starts with three writes in consecutive accesses: 0x50 to the device base (`start_addr & BASE_MASK`, default mask 0xF00), then 0x20 and 0xD0 to the region start address.
- R3: After the 0xD0 write, the engine reads the region start address until bit 7 of the read data is set. The next access after the ready read is a write of 0xFF to the region start address.
- R4: The poll budget is `timeout_lim` as latched at start, with 0 treated as 1. When that many polls have all returned bit 7 clear, polling stops, 0xFF is written to the region address and the error becomes timeout (6).
- R5: When a ready status has any bit of 0x7E set, it is ranked as follows. If bit 0x20 is clear, the code is hardware (1). Otherwise the code is low-voltage (2) if bit 0x08 is set, protected (3) if bit 0x02 is set, and erase failure (4) in all other cases. A ready status with no bit of 0x7E set leaves the error unchanged. Code 0 means no error.
- R6: After the 0xFF write, every word of the region is read at ascending addresses and compared with all-ones. The first mismatch ends the whole operation. It records verify (5) only if no error was recorded earlier, and otherwise keeps the earlier code.
- R7: The boot split applies when `boot_sel` is high and `start_addr - device base` equals `BOOT_OFS` (default 0x0C0). In that case the region lengths are the table entries in order (default 8, 8, 16, 0), each region starts where the previous one ended, and a zero entry or the end of the table finishes the block. In every other case the block is one region of `BLOCK_WORDS` (default 64) words.
- R8: `busy` goes high on the clock after an accepted `start` and stays high through a one-cycle `done`. `err_code` is valid in the `done` cycle. A `start` that arrives while `busy` is high changes nothing.
- R9: `flash_we` is high exactly while `busy` is high, and no bus access happens while it is low.
- R10: A status error or a timeout does not stop the block. The remaining verify reads and regions still run, and a later status error replaces an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| start_addr | input | AW | Word address of the block to erase |
| boot_sel | input | 1 | Device has a boot region split into sub-sectors |
| timeout_lim | input | TW | Poll budget per region |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result code (0 ok … 6 timeout) |
| flash_we | output | 1 | Write enable to the flash for the whole operation |
| bus_addr | output | AW | Bus word address |
| bus_wdata | output | DW | Bus write data |
| bus_wr | output | 1 | Bus write strobe |
| bus_rd | output | 1 | Bus read strobe, data sampled in the same cycle |
| bus_rdata | input | DW | Bus read data |

## Verification
A wrong region pointer or length counter shows on `bus_addr` within one access: a verify read lands on the wrong word, or a region starts at the wrong place, and the recorded access trace then differs from the expected one. A corrupted poll budget or a misread status shows up as an extra or missing poll read before the 0xFF write, and later as a wrong `err_code` when `done` pulses. A control state that fails to return to idle shows within one cycle of `done` as `busy` or `flash_we` still being high.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

   // Result codes reported on err_code
   typedef enum logic [2:0] {
      NES_OK      = 3'd0,
      NES_HW      = 3'd1,
      NES_LOWV    = 3'd2,
      NES_PROT    = 3'd3,
      NES_ERASE   = 3'd4,
      NES_VERIFY  = 3'd5,
      NES_TIMEOUT = 3'd6
   } nes_err_e;

   // Sequencer states
   typedef enum logic [3:0] {
      S_IDLE,
      S_SETUP,
      S_CLR,
      S_ERS,
      S_CNF,
      S_POLL,
      S_RST,
      S_VER,
      S_DONE
   } nes_state_e;

   // Device command bytes
   localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
   localparam logic [7:0] CMD_ERASE      = 8'h20;
   localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
   localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;

   // Status word bit positions
   localparam int ST_READY = 7;
   localparam int ST_ERASE = 5;
   localparam int ST_LOWV  = 3;
   localparam int ST_PROT  = 1;
   localparam logic [7:0] ST_ERR_MASK = 8'h7E;

endpackage

// File: rtl/nes_status_decode.sv
module nes_status_decode
   import nor_erase_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [DW-1:0] stat,
   output logic          ready,
   output nes_err_e      code
);

   logic [7:0] low;

   if (DW < 8) begin : g_bad_width
      $error("status word needs at least 8 bits");
   end

   assign low   = stat[7:0];
   assign ready = low[ST_READY];

   // Ranked classification of the flag bits
   always_comb begin
      code = NES_OK;
      if ((low & ST_ERR_MASK) != 8'h00) begin
         if (!low[ST_ERASE])    code = NES_HW;
         else if (low[ST_LOWV]) code = NES_LOWV;
         else if (low[ST_PROT]) code = NES_PROT;
         else                   code = NES_ERASE;
      end
   end

endmodule

// File: rtl/nes_poll_timer.sv
module nes_poll_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [TW-1:0] lim,
   output logic          last
);

   logic [TW-1:0] cnt_q;

   if (TW < 1) begin : g_bad_tw
      $error("timer width must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (load)                   cnt_q <= lim;
      else if (step && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   // A budget of zero behaves like a budget of one poll
   assign last = (cnt_q <= TW'(1));

   AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !load) |=> cnt_q == '0); // R4

endmodule

// File: rtl/nes_region_plan.sv
module nes_region_plan #(
   parameter int AW = 12,
   parameter int LW = 8,
   parameter int IW = 3,
   parameter int BLOCK_WORDS = 64,
   parameter int NSUB = 4,
   parameter int SUB_LW = 8,
   parameter logic [NSUB*SUB_LW-1:0] SUB_LENS = '0,
   parameter logic [AW-1:0] BASE_MASK = '0,
   parameter logic [AW-1:0] BOOT_OFS = '0,
   parameter bit BOOT_EN = 1'b1
) (
   input  logic [AW-1:0] blk_addr,
   input  logic          boot_req,
   input  logic [IW-1:0] idx,
   output logic [AW-1:0] dev_base,
   output logic          boot_hit,
   output logic [LW-1:0] reg_len
);

   logic [LW-1:0] tbl [NSUB];

   if (SUB_LW > LW) begin : g_bad_lw
      $error("region length width too narrow for the sub-sector table");
   end

   for (genvar g = 0; g < NSUB; g++) begin : g_tbl
      assign tbl[g] = LW'(SUB_LENS[g*SUB_LW +: SUB_LW]);
   end

   assign dev_base = blk_addr & BASE_MASK;

   if (BOOT_EN) begin : g_boot
      assign boot_hit = boot_req && ((blk_addr - dev_base) == BOOT_OFS);
   end else begin : g_flat
      assign boot_hit = 1'b0;
   end

   // Length of region number idx; zero marks the end of the block
   always_comb begin
      reg_len = '0;
      if (boot_hit) begin
         for (int k = 0; k < NSUB; k++) begin
            if (idx == IW'(k)) reg_len = tbl[k];
         end
      end else if (idx == '0) begin
         reg_len = LW'(BLOCK_WORDS);
      end
   end

endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
   import nor_erase_pkg::*;
#(
   parameter int AW = 12,
   parameter int DW = 16,
   parameter int TW = 8,
   parameter int BLOCK_WORDS = 64,
   parameter int NSUB = 4,
   parameter int SUB_LW = 8,
   parameter logic [NSUB*SUB_LW-1:0] SUB_LENS = {8'd0, 8'd16, 8'd8, 8'd8},
   parameter logic [AW-1:0] BASE_MASK = 12'hF00,
   parameter logic [AW-1:0] BOOT_OFS = 12'h0C0,
   parameter bit BOOT_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   input  logic          boot_sel,
   input  logic [TW-1:0] timeout_lim,
   output logic          busy,
   output logic          done,
   output logic [2:0]    err_code,
   output logic          flash_we,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   output logic          bus_wr,
   output logic          bus_rd,
   input  logic [DW-1:0] bus_rdata
);

   localparam int BW = $clog2(BLOCK_WORDS + 1);
   localparam int LW = (BW > SUB_LW) ? BW : SUB_LW;
   localparam int IW = $clog2(NSUB + 1) + 1;

   if (BLOCK_WORDS < 1) begin : g_bad_blk
      $error("block must hold at least one word");
   end
   if (NSUB < 1) begin : g_bad_nsub
      $error("sub-sector table needs at least one entry");
   end
   if (AW < 2) begin : g_bad_aw
      $error("address width too small");
   end

   nes_state_e    st_q;
   logic [AW-1:0] addr_q;
   logic          boot_q;
   logic [TW-1:0] tlim_q;
   logic [AW-1:0] ptr_q;
   logic [LW-1:0] rem_q;
   logic [IW-1:0] idx_q;
   nes_err_e      err_q;

   logic [AW-1:0] dev_base;
   logic          boot_hit;
   logic [LW-1:0] reg_len;
   logic          stat_ready;
   nes_err_e      stat_code;
   logic          tmr_last;
   logic          tmr_load;
   logic          tmr_step;
   logic          word_blank;

   nes_region_plan #(
      .AW(AW), .LW(LW), .IW(IW), .BLOCK_WORDS(BLOCK_WORDS), .NSUB(NSUB),
      .SUB_LW(SUB_LW), .SUB_LENS(SUB_LENS), .BASE_MASK(BASE_MASK),
      .BOOT_OFS(BOOT_OFS), .BOOT_EN(BOOT_EN)
   ) u_plan (
      .blk_addr (addr_q),
      .boot_req (boot_q),
      .idx      (idx_q),
      .dev_base (dev_base),
      .boot_hit (boot_hit),
      .reg_len  (reg_len)
   );

   nes_status_decode #(.DW(DW)) u_dec (
      .stat  (bus_rdata),
      .ready (stat_ready),
      .code  (stat_code)
   );

   assign tmr_load = (st_q == S_CNF);
   assign tmr_step = (st_q == S_POLL) && !stat_ready;

   nes_poll_timer #(.TW(TW)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .step  (tmr_step),
      .lim   (tlim_q),
      .last  (tmr_last)
   );

   assign word_blank = (bus_rdata == '1);

   // Sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         addr_q <= '0;
         boot_q <= 1'b0;
         tlim_q <= '0;
         ptr_q  <= '0;
         rem_q  <= '0;
         idx_q  <= '0;
         err_q  <= NES_OK;
      end else begin
         unique case (st_q)
            S_IDLE: begin
               if (start) begin
                  addr_q <= start_addr;
                  boot_q <= boot_sel;
                  tlim_q <= timeout_lim;
                  ptr_q  <= start_addr;
                  idx_q  <= '0;
                  err_q  <= NES_OK;
                  st_q   <= S_SETUP;
               end
            end
            S_SETUP: begin
               if (reg_len == '0) begin
                  st_q <= S_DONE;
               end else begin
                  rem_q <= reg_len;
                  st_q  <= S_CLR;
               end
            end
            S_CLR: st_q <= S_ERS;
            S_ERS: st_q <= S_CNF;
            S_CNF: st_q <= S_POLL;
            S_POLL: begin
               if (stat_ready) begin
                  if (stat_code != NES_OK) err_q <= stat_code;
                  st_q <= S_RST;
               end else if (tmr_last) begin
                  err_q <= NES_TIMEOUT;
                  st_q  <= S_RST;
               end
            end
            S_RST: st_q <= S_VER;
            S_VER: begin
               if (!word_blank) begin
                  if (err_q == NES_OK) err_q <= NES_VERIFY;
                  st_q <= S_DONE;
               end else begin
                  ptr_q <= ptr_q + 1'b1;
                  if (rem_q == LW'(1)) begin
                     idx_q <= idx_q + 1'b1;
                     st_q  <= S_SETUP;
                  end else begin
                     rem_q <= rem_q - 1'b1;
                  end
               end
            end
            S_DONE: st_q <= S_IDLE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   // Bus drive, one access per state
   always_comb begin
      bus_addr  = ptr_q;
      bus_wdata = '0;
      bus_wr    = 1'b0;
      bus_rd    = 1'b0;
      unique case (st_q)
         S_CLR: begin
            bus_addr  = dev_base;
            bus_wdata = DW'(CMD_CLR_STAT);
            bus_wr    = 1'b1;
         end
         S_ERS: begin
            bus_wdata = DW'(CMD_ERASE);
            bus_wr    = 1'b1;
         end
         S_CNF: begin
            bus_wdata = DW'(CMD_CONFIRM);
            bus_wr    = 1'b1;
         end
         S_RST: begin
            bus_wdata = DW'(CMD_READ_ARRAY);
            bus_wr    = 1'b1;
         end
         S_POLL, S_VER: bus_rd = 1'b1;
         default: ;
      endcase
   end

   assign busy     = (st_q != S_IDLE);
   assign done     = (st_q == S_DONE);
   assign flash_we = busy;
   assign err_code = err_q;

   AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd)); // R2
   AST_POLL_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && st_q == S_POLL && bus_rdata[ST_READY]) |=>
      (bus_wr && bus_wdata == DW'(CMD_READ_ARRAY))); // R3
   AST_VERIFY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_VER && !word_blank) |=> done); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && start) |=> $stable(addr_q) && $stable(tlim_q)); // R8
   AST_WE_COVERS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr || bus_rd) |-> flash_we); // R9

endmodule

// File: tb/sim_nor_erase_seq.sv
module sim_nor_erase_seq;
   localparam int AW = 12;
   localparam int DW = 16;
   localparam int TW = 8;
   localparam int TRW = 1 + AW + DW;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n;
   logic          start;
   logic [AW-1:0] start_addr;
   logic          boot_sel;
   logic [TW-1:0] timeout_lim;
   logic          busy, done, flash_we, bus_wr, bus_rd;
   logic [2:0]    err_code;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata;

   nor_erase_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .boot_sel(boot_sel), .timeout_lim(timeout_lim), .busy(busy), .done(done),
      .err_code(err_code), .flash_we(flash_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
   );

   // Device model: array contents plus status mode after a confirm write
   logic [DW-1:0] mem [0:4095];
   logic          stat_mode;
   int            pcount;
   int            poll_n;
   logic [6:0]    stat_lo;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_mode <= 1'b0;
         pcount    <= 0;
      end else if (bus_wr) begin
         if (bus_wdata == 16'h00D0) begin
            stat_mode <= 1'b1;
            pcount    <= 0;
         end else if (bus_wdata == 16'h00FF) begin
            stat_mode <= 1'b0;
         end
      end else if (bus_rd && stat_mode) begin
         pcount <= pcount + 1;
      end
   end

   assign bus_rdata = stat_mode ? ((pcount < poll_n) ? 16'h0000 : {8'h00, 1'b1, stat_lo})
                                : mem[bus_addr];

   // Access trace recorder
   logic [TRW-1:0] tr [0:1023];
   int             trn;
   bit             rec_on;

   always @(negedge clk) begin
      if (rec_on && (bus_wr || bus_rd) && trn < 1024) begin
         tr[trn] = {bus_wr, bus_addr, bus_wr ? bus_wdata : 16'h0000};
         trn++;
      end
   end

   int nvec = 0;
   int nfail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Expected model built from the requirements
   logic [TRW-1:0] etr [0:1023];
   int             etn;
   int             exp_err;

   function automatic int sublen(input int r);
      case (r)
         0: return 8;
         1: return 8;
         2: return 16;
         default: return 0;
      endcase
   endfunction

   function automatic int rank(input logic [6:0] s);
      if ((s & 7'h7E) == 7'h00) return 0;
      if (!s[5]) return 1;
      if (s[3]) return 2;
      if (s[1]) return 3;
      return 4;
   endfunction

   task automatic push(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      if (etn < 1024) etr[etn] = {w, a, d};
      etn++;
   endtask

   task automatic build_exp(input logic [AW-1:0] a, input logic bf, input int lim,
                            input int pn, input logic [6:0] sl);
      logic [AW-1:0] base, p;
      bit boot, stop;
      int len, lim1, e;
      base = a & 12'hF00;
      boot = bf && ((a - base) == 12'h0C0);
      p = a; stop = 0; etn = 0; exp_err = 0;
      lim1 = (lim < 1) ? 1 : lim;
      for (int r = 0; r < 4 && !stop; r++) begin
         len = boot ? sublen(r) : ((r == 0) ? 64 : 0);
         if (len == 0) break;
         push(1, base, 16'h0050);
         push(1, p, 16'h0020);
         push(1, p, 16'h00D0);
         if (pn >= lim1) begin
            for (int i = 0; i < lim1; i++) push(0, p, 16'h0000);
            exp_err = 6;
         end else begin
            for (int i = 0; i <= pn; i++) push(0, p, 16'h0000);
            e = rank(sl);
            if (e != 0) exp_err = e;
         end
         push(1, p, 16'h00FF);
         for (int i = 0; i < len; i++) begin
            push(0, p + AW'(i), 16'h0000);
            if (mem[p + AW'(i)] != 16'hFFFF) begin
               if (exp_err == 0) exp_err = 5;
               stop = 1;
               break;
            end
         end
         p = p + AW'(len);
      end
   endtask

   task automatic run_op(input logic [AW-1:0] a, input logic bf, input int lim,
                         input int pn, input logic [6:0] sl, input bit poke,
                         input string tag);
      int cyc;
      int bad;
      poll_n  = pn;
      stat_lo = sl;
      build_exp(a, bf, lim, pn, sl);
      trn    = 0;
      rec_on = 1;
      @(negedge clk);
      start = 1'b1; start_addr = a; boot_sel = bf; timeout_lim = TW'(lim);
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R8", "busy after start", busy, 1);
      chk(flash_we == 1'b1, "R9", "write enable after start", flash_we, 1);
      if (poke) begin
         // R8: a second start while busy must not disturb the operation
         start = 1'b1; start_addr = a ^ 12'h040; boot_sel = ~bf; timeout_lim = 8'd1;
         @(negedge clk);
         start = 1'b0;
      end
      cyc = 0;
      while (!done && cyc < 3000) begin
         @(negedge clk);
         cyc++;
      end
      if (!done) begin
         chk(0, "R8", "done never pulsed", 0, 1);
      end else begin
         chk(err_code == 3'(exp_err), tag, "error code", err_code, exp_err);
         chk(busy && flash_we, "R9", "busy and enable in done cycle", {busy, flash_we}, 3);
         @(negedge clk);
         chk(!busy && !done && !flash_we, "R8", "idle after done", {busy, done, flash_we}, 0);
      end
      rec_on = 0;
      bad = -1;
      for (int i = 0; i < trn && i < etn; i++) begin
         if (bad < 0 && tr[i] != etr[i]) bad = i;
      end
      chk(trn == etn, "R2 R7", "access count", trn, etn);
      if (bad >= 0) chk(0, "R2 R3 R6", $sformatf("access %0d", bad), tr[bad], etr[bad]);
      else chk(1, "R2 R3 R6", "access sequence", 0, 0);
      repeat (2) @(negedge clk);
   endtask

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   logic [6:0] stat_pick [0:7];

   initial begin
      logic [AW-1:0] a;
      logic bf;
      int lim, pn, pos;
      logic [6:0] sl;
      stat_pick[0] = 7'h00; stat_pick[1] = 7'h20; stat_pick[2] = 7'h28; stat_pick[3] = 7'h22;
      stat_pick[4] = 7'h2A; stat_pick[5] = 7'h02; stat_pick[6] = 7'h01; stat_pick[7] = 7'h10;
      for (int i = 0; i < 4096; i++) mem[i] = 16'hFFFF;
      poll_n = 0; stat_lo = 7'h00;
      rec_on = 0; trn = 0;
      rst_n = 1'b0; start = 1'b0; start_addr = '0; boot_sel = 1'b0; timeout_lim = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !flash_we, "R1", "status in reset", {busy, done, flash_we}, 0);
      chk(!bus_wr && !bus_rd, "R1", "strobes in reset", {bus_wr, bus_rd}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !bus_wr && !bus_rd, "R1", "idle after reset", {busy, bus_wr, bus_rd}, 0);

      // Directed corner cases
      run_op(12'h340, 1'b0, 5, 2, 7'h00, 0, "R2");          // plain block, clean
      run_op(12'h5C0, 1'b1, 5, 1, 7'h00, 0, "R7");          // boot walk 8,8,16
      run_op(12'h5C0, 1'b0, 5, 1, 7'h00, 0, "R7");          // boot offset, flag low
      run_op(12'h580, 1'b1, 5, 0, 7'h00, 0, "R7");          // flag high, not boot offset
      run_op(12'h100, 1'b0, 3, 10, 7'h00, 0, "R4");         // timeout after 3 polls
      run_op(12'h200, 1'b0, 0, 5, 7'h00, 0, "R4");          // zero budget acts as one
      run_op(12'h240, 1'b0, 4, 3, 7'h00, 0, "R3");          // ready on the last allowed poll
      run_op(12'h000, 1'b0, 6, 1, 7'h28, 0, "R5");          // low-voltage
      run_op(12'h000, 1'b0, 6, 1, 7'h22, 0, "R5");          // protected
      run_op(12'h000, 1'b0, 6, 1, 7'h20, 0, "R5");          // plain erase failure
      run_op(12'h000, 1'b0, 6, 1, 7'h02, 0, "R5");          // hardware: erase bit clear
      run_op(12'h000, 1'b0, 6, 1, 7'h2A, 0, "R5");          // ranking: low-voltage wins
      run_op(12'h000, 1'b0, 6, 1, 7'h01, 0, "R5");          // bit outside mask ignored
      run_op(12'h9C0, 1'b1, 6, 0, 7'h22, 0, "R10");         // error in every region, walk continues
      mem[12'h47F] = 16'hFF7F;
      run_op(12'h440, 1'b0, 6, 0, 7'h00, 0, "R6");          // last word not blank
      run_op(12'h440, 1'b0, 6, 0, 7'h20, 0, "R6");          // earlier error kept
      mem[12'h47F] = 16'hFFFF;
      mem[12'hBC9] = 16'h0000;
      run_op(12'hBC0, 1'b1, 6, 0, 7'h00, 0, "R6");          // mismatch in second sub-sector
      mem[12'hBC9] = 16'hFFFF;
      run_op(12'h7C0, 1'b1, 2, 0, 7'h00, 1, "R8");          // start while busy ignored

      // Constrained random
      void'($urandom(32'd7321));
      for (int k = 0; k < 40; k++) begin
         a   = {4'($urandom % 16), 2'($urandom % 4), 6'b0};
         bf  = 1'($urandom % 2);
         if ($urandom % 3 == 0) begin a[7:6] = 2'b11; bf = 1'b1; end
         lim = $urandom % 7;
         pn  = $urandom % 8;
         sl  = stat_pick[$urandom % 8];
         pos = -1;
         if ($urandom % 4 == 0) begin
            pos = int'(a) + ($urandom % 70);
            mem[pos] = 16'hBEEF;
         end
         run_op(a, bf, lim, pn, sl, k % 9 == 0, "R10");
         if (pos >= 0) mem[pos] = 16'hFFFF;
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule